// File: doc/BRIEF.md
# Interrupt Controller Core Wake Manager

This block manages sleep and wake for every core of a cluster that an interrupt redistributor serves. Software writes a per-core sleep request bit before the core is powered down, then polls a per-core asleep status that goes high only after the core's stream link to its CPU interface has drained. The stream link is modelled as an outstanding-transaction counter: it counts up on each request and down on each acknowledge. When every core of the cluster reports asleep, a gate-permit output tells the power logic that the cluster's stream link may be power gated.

One interrupt at a time is held in a pending register, together with a target vector. A single-target interrupt goes to its core whatever that core's activity input says. A multi-target interrupt prefers awake cores whose activity input is high. No interrupt is forwarded to a core whose sleep bit is set. If no target can take the interrupt, it stays pending and a wake request is raised to the external power controller for the lowest-numbered target. That request is held until software clears the core's sleep bit.

Each core runs a state machine with states SLOT_AWAKE, SLOT_DRAINING and SLOT_ASLEEP. The transitions are:
- go_sleep: AWAKE to DRAINING, on a sleep-set write.
- drained: DRAINING to ASLEEP, when the count is zero and no request arrives.
- late_request: ASLEEP to DRAINING, when a request arrives.
- wake_up: DRAINING or ASLEEP to AWAKE, on a sleep-clear write.

The dispatcher has states DISP_IDLE and DISP_HELD. The transitions are:
- accept: IDLE to HELD.
- deliver: HELD to IDLE.
- stall: HELD to HELD.

Top module: `irq_wake_mgr`

## Requirements
- R1: A write with `wr_en`=1 sets (`wr_sleep`=1) or clears (`wr_sleep`=0) the sleep bit of core `wr_core`. The new value shows on `sleep_o[wr_core]` from the cycle after the write. Reset clears all sleep bits.
- R2: `asleep_o[i]` rises in the cycle after a cycle in which core i's sleep bit is 1, its outstanding count is 0 and `txn_req[i]` is low. It is never 1 while the sleep bit is 0.
- R3: The outstanding count of core i rises by one on `txn_req[i]` and falls by one on `txn_ack[i]`. The count is unchanged when both are high. While the count is non-zero, `asleep_o[i]` stays 0. A request while asleep sends the core back to draining, so `asleep_o[i]` falls in the next cycle.
- R4: `wake_req_o[i]` rises in the cycle after a cycle in which the pending interrupt cannot be delivered and i is its lowest-numbered target with its sleep bit set. It stays high until a sleep-clear write to core i, and it is 0 in the cycle after that write.
- R5: A pending interrupt with a single target (one bit set in the target vector, bit i meaning core i) is delivered to that core whenever its sleep bit is 0, whatever `cpu_active` shows.
- R6: A pending multi-target interrupt is delivered to the lowest-numbered target whose sleep bit is 0 and whose `cpu_active` is 1. `deliver_o` is one-hot, with bit i meaning core i.
- R7: If no target has both a clear sleep bit and `cpu_active`=1, the interrupt goes to the lowest-numbered target whose sleep bit is 0.
- R8: If every target has its sleep bit set, the interrupt stays pending with `deliver_o`=0.
- R9: `deliver_o[i]` is never 1 while `sleep_o[i]` is 1.
- R10: `cluster_gate_ok` is 1 exactly when every bit of `asleep_o` is 1.
- R11: `irq_ready` is 1 when nothing is pending. An interrupt with `irq_valid`=1 and a non-zero target vector is taken while `irq_ready`=1, and `irq_ready` is 0 from the next cycle until the cycle after the interrupt is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Sleep bit write strobe |
| wr_core | input | IDX_W | Core selected by the write |
| wr_sleep | input | 1 | Value written to the sleep bit |
| sleep_o | output | NUM_CORES | Sleep request bits, readable |
| asleep_o | output | NUM_CORES | Per-core asleep status |
| txn_req | input | NUM_CORES | Stream transaction issued, per core |
| txn_ack | input | NUM_CORES | Stream transaction completed, per core |
| cpu_active | input | NUM_CORES | Per-core activity hint for multi-target steering |
| irq_valid | input | 1 | Interrupt offered |
| irq_targets | input | NUM_CORES | Eligible target cores of the offered interrupt |
| irq_ready | output | 1 | Pending slot free |
| deliver_o | output | NUM_CORES | One-hot delivery of the pending interrupt |
| wake_req_o | output | NUM_CORES | Wake requests to the power controller |
| cluster_gate_ok | output | 1 | Cluster stream link may be power gated |

## Verification
Two events can land in the same cycle: a sleep write to a core, and the pending interrupt resolving on that same core. The bench forces both cases. In the first, a set write meets a delivery; the delivery must go through because the sleep bit is not yet registered. In the second, a clear write meets a stalled interrupt; the wake request must stay low, and the interrupt must be delivered in the next cycle. A cycle-accurate reference model in the bench judges every output in every cycle, across random writes, transactions and target vectors.

// File: rtl/iwm_pkg.sv
package iwm_pkg;
    typedef enum logic [1:0] {
        SLOT_AWAKE    = 2'd0,
        SLOT_DRAINING = 2'd1,
        SLOT_ASLEEP   = 2'd2
    } slot_state_t;

    typedef enum logic {
        DISP_IDLE = 1'b0,
        DISP_HELD = 1'b1
    } disp_state_t;
endpackage

// File: rtl/iwm_core_slot.sv
module iwm_core_slot
    import iwm_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_set,
    input  logic wr_clr,
    input  logic txn_req,
    input  logic txn_ack,
    input  logic wake_hit,
    output logic sleep_o,
    output logic asleep_o,
    output logic wake_o
);
    slot_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wake_q;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_AWAKE:    if (wr_set) state_d = SLOT_DRAINING;
            SLOT_DRAINING: begin
                if (wr_clr)                          state_d = SLOT_AWAKE;
                else if (cnt_q == '0 && !txn_req)    state_d = SLOT_ASLEEP;
            end
            SLOT_ASLEEP: begin
                if (wr_clr)       state_d = SLOT_AWAKE;
                else if (txn_req) state_d = SLOT_DRAINING;
            end
            default:       state_d = SLOT_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            if (txn_req && !txn_ack)      cnt_q <= cnt_q + ONE;
            else if (txn_ack && !txn_req) cnt_q <= cnt_q - ONE;
            if (wr_clr)                   wake_q <= 1'b0;
            else                          wake_q <= sleep_o && (wake_q || wake_hit);
        end
    end

    always_comb begin
        sleep_o  = (state_q != SLOT_AWAKE);
        asleep_o = (state_q == SLOT_ASLEEP);
        wake_o   = wake_q;
    end
endmodule

// File: rtl/iwm_dispatch.sv
module iwm_dispatch
    import iwm_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 irq_valid,
    input  logic [NUM_CORES-1:0] irq_targets,
    input  logic [NUM_CORES-1:0] cpu_active,
    input  logic [NUM_CORES-1:0] core_sleep,
    output logic                 irq_ready,
    output logic [NUM_CORES-1:0] deliver,
    output logic [NUM_CORES-1:0] wake_hit
);
    disp_state_t          state_q, state_d;
    logic [NUM_CORES-1:0] tgt_q;
    logic [NUM_CORES-1:0] pref_set, awake_set;

    function automatic logic [NUM_CORES-1:0] lowest(input logic [NUM_CORES-1:0] v);
        return v & (~v + {{(NUM_CORES-1){1'b0}}, 1'b1});
    endfunction

    always_comb begin
        awake_set = tgt_q & ~core_sleep;
        pref_set  = awake_set & cpu_active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DISP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                          tgt_q <= '0;
        else if (state_q == DISP_IDLE && irq_valid && |irq_targets) tgt_q <= irq_targets;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DISP_IDLE: if (irq_valid && |irq_targets) state_d = DISP_HELD;
            DISP_HELD: if (|awake_set)                state_d = DISP_IDLE;
            default:                                  state_d = DISP_IDLE;
        endcase
    end

    always_comb begin
        irq_ready = 1'b0;
        deliver   = '0;
        wake_hit  = '0;
        unique case (state_q)
            DISP_IDLE: irq_ready = 1'b1;
            DISP_HELD: begin
                if (|pref_set)       deliver  = lowest(pref_set);
                else if (|awake_set) deliver  = lowest(awake_set);
                else                 wake_hit = lowest(tgt_q);
            end
            default:   irq_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_wake_mgr.sv
module irq_wake_mgr #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 4,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_core,
    input  logic                 wr_sleep,
    output logic [NUM_CORES-1:0] sleep_o,
    output logic [NUM_CORES-1:0] asleep_o,
    input  logic [NUM_CORES-1:0] txn_req,
    input  logic [NUM_CORES-1:0] txn_ack,
    input  logic [NUM_CORES-1:0] cpu_active,
    input  logic                 irq_valid,
    input  logic [NUM_CORES-1:0] irq_targets,
    output logic                 irq_ready,
    output logic [NUM_CORES-1:0] deliver_o,
    output logic [NUM_CORES-1:0] wake_req_o,
    output logic                 cluster_gate_ok
);
    logic [NUM_CORES-1:0] wake_hit;

    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_core == IDX_W'(gi));
        iwm_core_slot #(.CNT_W(CNT_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_set   (sel && wr_sleep),
            .wr_clr   (sel && !wr_sleep),
            .txn_req  (txn_req[gi]),
            .txn_ack  (txn_ack[gi]),
            .wake_hit (wake_hit[gi]),
            .sleep_o  (sleep_o[gi]),
            .asleep_o (asleep_o[gi]),
            .wake_o   (wake_req_o[gi])
        );
    end

    iwm_dispatch #(.NUM_CORES(NUM_CORES)) disp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_valid   (irq_valid),
        .irq_targets (irq_targets),
        .cpu_active  (cpu_active),
        .core_sleep  (sleep_o),
        .irq_ready   (irq_ready),
        .deliver     (deliver_o),
        .wake_hit    (wake_hit)
    );

    assign cluster_gate_ok = &asleep_o;
endmodule

// File: rtl/iwm_checker.sv
module iwm_checker #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] sleep_o,
    input logic [NUM_CORES-1:0] asleep_o,
    input logic                 irq_valid,
    input logic [NUM_CORES-1:0] irq_targets,
    input logic                 irq_ready,
    input logic [NUM_CORES-1:0] deliver_o,
    input logic [NUM_CORES-1:0] wake_req_o,
    input logic                 cluster_gate_ok
);
    AST_ASLEEP_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_o & ~sleep_o) == '0); // R2
    AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o & ~sleep_o) == '0); // R4
    AST_DELIVER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(deliver_o)); // R6
    AST_NO_DELIVER_SLEEPING: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_o & sleep_o) == '0); // R9
    AST_GATE_ALL_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        cluster_gate_ok == (&asleep_o)); // R10
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ready && irq_valid && |irq_targets) |=> !irq_ready); // R11
    AST_DELIVER_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ready |-> deliver_o == '0); // R11
endmodule

bind irq_wake_mgr iwm_checker #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_o         (sleep_o),
    .asleep_o        (asleep_o),
    .irq_valid       (irq_valid),
    .irq_targets     (irq_targets),
    .irq_ready       (irq_ready),
    .deliver_o       (deliver_o),
    .wake_req_o      (wake_req_o),
    .cluster_gate_ok (cluster_gate_ok)
);

// File: tb/irq_wake_mgr_tb_top.sv
module irq_wake_mgr_tb_top;
    localparam int N       = 4;
    localparam int CW      = 4;
    localparam int IW      = 2;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n;
    logic wr_en, wr_sleep;
    logic [IW-1:0] wr_core;
    logic [N-1:0] sleep_o, asleep_o, txn_req, txn_ack, cpu_active, irq_targets;
    logic [N-1:0] deliver_o, wake_req_o;
    logic irq_valid, irq_ready, cluster_gate_ok;

    int compared = 0, mismatched = 0;

    // reference model state
    int          m_st [N];
    int          m_cnt[N];
    logic [N-1:0] m_wake;
    logic        m_pend;
    logic [N-1:0] m_tgt;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_wake_mgr #(.NUM_CORES(N), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_core(wr_core), .wr_sleep(wr_sleep),
        .sleep_o(sleep_o), .asleep_o(asleep_o), .txn_req(txn_req), .txn_ack(txn_ack),
        .cpu_active(cpu_active), .irq_valid(irq_valid), .irq_targets(irq_targets),
        .irq_ready(irq_ready), .deliver_o(deliver_o), .wake_req_o(wake_req_o),
        .cluster_gate_ok(cluster_gate_ok)
    );

    function automatic logic [N-1:0] low_bit(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
        return '0;
    endfunction

    function automatic logic [N-1:0] exp_sleep();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (m_st[i] != 0);
        return r;
    endfunction

    function automatic logic [N-1:0] exp_asleep();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (m_st[i] == 2);
        return r;
    endfunction

    function automatic logic [N-1:0] exp_deliver(input logic [N-1:0] act);
        logic [N-1:0] aw;
        if (!m_pend) return '0;
        aw = m_tgt & ~exp_sleep();
        if (|(aw & act)) return low_bit(aw & act);
        return low_bit(aw);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reset_model();
        for (int i = 0; i < N; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
        m_wake = '0; m_pend = 1'b0; m_tgt = '0;
    endtask

    // compare all outputs against the model, then advance the model by one edge
    task automatic step();
        logic [N-1:0] sl, dl, hit;
        #1;
        sl = exp_sleep();
        dl = exp_deliver(cpu_active);
        hit = (m_pend && dl == '0) ? low_bit(m_tgt) : '0;
        chk("R1 sleep_o", 32'(sleep_o), 32'(sl));
        chk("R2/R3 asleep_o", 32'(asleep_o), 32'(exp_asleep()));
        chk("R4 wake_req_o", 32'(wake_req_o), 32'(m_wake));
        chk("R5-R9 deliver_o", 32'(deliver_o), 32'(dl));
        chk("R10 cluster_gate_ok", 32'(cluster_gate_ok), 32'(&exp_asleep()));
        chk("R11 irq_ready", 32'(irq_ready), 32'(!m_pend));
        for (int i = 0; i < N; i++) begin
            logic set, clr;
            set = wr_en && wr_core == IW'(i) && wr_sleep;
            clr = wr_en && wr_core == IW'(i) && !wr_sleep;
            m_wake[i] = clr ? 1'b0 : (sl[i] && (m_wake[i] || hit[i]));
            case (m_st[i])
                0: if (set) m_st[i] = 1;
                1: if (clr) m_st[i] = 0; else if (m_cnt[i] == 0 && !txn_req[i]) m_st[i] = 2;
                default: if (clr) m_st[i] = 0; else if (txn_req[i]) m_st[i] = 1;
            endcase
            m_cnt[i] = m_cnt[i] + int'(txn_req[i]) - int'(txn_ack[i]);
        end
        if (m_pend) m_pend = (dl == '0);
        else if (irq_valid && |irq_targets) begin m_pend = 1'b1; m_tgt = irq_targets; end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_core = '0; wr_sleep = 0; txn_req = '0; txn_ack = '0;
        cpu_active = '1; irq_valid = 0; irq_targets = '0;
    endtask

    task automatic write_sleep(input int core, input logic val);
        @(negedge clk); idle_inputs();
        wr_en = 1; wr_core = IW'(core); wr_sleep = val; step();
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin @(negedge clk); idle_inputs(); step(); end
    endtask

    task automatic offer(input logic [N-1:0] t, input logic [N-1:0] act);
        @(negedge clk); idle_inputs();
        irq_valid = 1; irq_targets = t; cpu_active = act; step();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        idle_inputs();
        rst_n = 0;
        reset_model();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state: R1 R2 R4 R10 R11
        idle_cycles(1);

        // R2/R3: outstanding transaction delays asleep
        @(negedge clk); idle_inputs(); txn_req = 4'b0100; step();
        write_sleep(2, 1);
        idle_cycles(2);
        @(negedge clk); idle_inputs(); txn_ack = 4'b0100; step();
        idle_cycles(2);
        // R4: single target to sleeping core 2
        offer(4'b0100, 4'b0000);
        idle_cycles(3);
        write_sleep(2, 0);   // wake clears, R5 delivery follows
        idle_cycles(2);

        // R6 and R7: multi-target steering
        offer(4'b1110, 4'b1000); idle_cycles(2);
        offer(4'b0110, 4'b0000); idle_cycles(2);
        // R5: single target with cpu_active low
        offer(4'b0001, 4'b0000); idle_cycles(2);

        // R8/R10: all cores asleep, multi-target stays pending
        for (int c = 0; c < N; c++) write_sleep(c, 1);
        idle_cycles(2);
        offer(4'b1010, 4'b1111); idle_cycles(3);
        write_sleep(1, 0); idle_cycles(2);
        // R3: late request while asleep
        @(negedge clk); idle_inputs(); txn_req = 4'b0001; step();
        @(negedge clk); idle_inputs(); txn_ack = 4'b0001; step();
        idle_cycles(2);
        for (int c = 0; c < N; c++) write_sleep(c, 0);

        // same-cycle: set write while delivery lands on that core (R9)
        offer(4'b0010, 4'b1111);
        @(negedge clk); idle_inputs(); wr_en = 1; wr_core = 2'd1; wr_sleep = 1; step();
        idle_cycles(2);
        // same-cycle: clear write while stalled interrupt targets core 1 (R4)
        offer(4'b0010, 4'b1111);
        @(negedge clk); idle_inputs(); wr_en = 1; wr_core = 2'd1; wr_sleep = 0; step();
        idle_cycles(2);

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk); idle_inputs();
            wr_en = ($urandom_range(0, 7) == 0);
            wr_core = IW'($urandom_range(0, N-1));
            wr_sleep = $urandom_range(0, 2) != 0;
            cpu_active = N'($urandom);
            irq_valid = $urandom_range(0, 3) == 0;
            irq_targets = N'($urandom_range(1, (1 << N) - 1));
            for (int i = 0; i < N; i++) begin
                txn_req[i] = (m_cnt[i] < 14) && ($urandom_range(0, 5) == 0);
                txn_ack[i] = (m_cnt[i] > 0) && ($urandom_range(0, 3) == 0);
            end
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule